// File: doc/BRIEF.md
# Wide Restoring Divider

This block divides a double-width dividend, supplied as a high word and a low word, by a single-width divisor. It returns a single-width quotient and a single-width remainder and works in either an unsigned or a two's-complement signed mode. The width is set by the parameter `DW`, which defaults to 64, so by default a 128-bit value is divided by a 64-bit one. A one-cycle `start` strobe loads the operands. The unit then works for a number of cycles that depends on the data and ends with a one-cycle `done` pulse. At that pulse the results are valid, or `div_err` is high.

The unit works on magnitudes. It first finds how far the divisor must be shifted left to pass the running dividend, stepping one bit per cycle, and stores that count. It then walks back down one bit per cycle. Each step shifts the quotient left, makes a trial subtraction, and either keeps the difference and sets the new quotient bit or restores the previous value. Signs are applied after the loop. A zero divisor is caught before any iteration. A quotient that cannot be held in `DW` bits is reported as a divide error, and the data outputs are cleared in that case.

Top module: `wide_divider`

## Requirements
- R1: In unsigned mode (`signed_mode`=0) with a nonzero divisor and a quotient below 2^DW, `quotient` equals floor({dividend_hi,dividend_lo} / divisor) and `remainder` equals the matching modulus, with `div_err`=0.
- R2: In signed mode (`signed_mode`=1) the dividend and divisor are read as two's complement. The quotient is truncated toward zero, and a nonzero remainder carries the sign of the dividend.
- R3: A zero divisor gives `div_err`=1 together with `done` exactly two cycles after the start strobe, with no iteration.
- R4: In unsigned mode, a quotient of 2^DW or more gives `div_err`=1.
- R5: In signed mode, a quotient outside -2^(DW-1) .. 2^(DW-1)-1 gives `div_err`=1. This includes the most negative dividend divided by -1.
- R6: Whenever `div_err`=1 at `done`, `quotient` and `remainder` both read zero.
- R7: After reset, `done`, `div_err`, `quotient` and `remainder` are zero. `done` is high for exactly one cycle per operation, and the outputs hold their values between completions.
- R8: A start strobe that arrives while an operation is in progress is ignored. It neither changes that operation's result nor causes a second completion.
- R9: The start-to-done latency never exceeds 4*DW+4 cycles. When the dividend magnitude is below the divisor magnitude, `done` comes exactly 4 cycles after start, and the quotient is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle strobe that loads the operands when the unit is idle |
| signed_mode | input | 1 | 1 selects two's-complement division, 0 selects unsigned |
| dividend_hi | input | DW | Upper half of the dividend |
| dividend_lo | input | DW | Lower half of the dividend |
| divisor | input | DW | Divisor |
| quotient | output | DW | Quotient; zero on error |
| remainder | output | DW | Remainder; zero on error |
| div_err | output | 1 | Divide error (zero divisor or quotient out of range), valid with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
Several properties are checked on every cycle: the one-cycle width of `done`, the holding of the outputs between completions, and the two-cycle turnaround for a zero divisor. The same checks confirm that error results are cleared, that an unsigned remainder stays below the divisor captured at start, and that the bounded latency is met. Whether the quotient and remainder are numerically right, including signs and truncation, is shown only by the bench scenarios. These compare every result against an arithmetic model over a near-exhaustive sweep at DW=4 and over selected 64-bit cases. The same holds for the exact overflow boundaries and for a start strobe ignored in mid-operation.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;

    // Controller phases; the idle phase must encode as zero for reset.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_NORM   = 3'd2,
        ST_REDUCE = 3'd3,
        ST_FINISH = 3'd4
    } wdiv_state_e;

endpackage

// File: rtl/wdiv_operand_prep.sv
// Converts the operands to magnitudes and reports their signs.
module wdiv_operand_prep #(
    parameter int DW = 64
) (
    input  logic              signed_mode_i,
    input  logic [2*DW-1:0]   dividend_i,
    input  logic [DW-1:0]     divisor_i,
    output logic [2*DW-1:0]   mag_dividend_o,
    output logic [DW-1:0]     mag_divisor_o,
    output logic              neg_dividend_o,
    output logic              neg_divisor_o
);
    localparam int W2 = 2 * DW;

    always_comb begin
        neg_dividend_o = signed_mode_i & dividend_i[W2-1];
        neg_divisor_o  = signed_mode_i & divisor_i[DW-1];
        mag_dividend_o = neg_dividend_o ? (~dividend_i + W2'(1)) : dividend_i;
        mag_divisor_o  = neg_divisor_o  ? (~divisor_i  + DW'(1)) : divisor_i;
    end

endmodule

// File: rtl/wdiv_step.sv
// Datapath for one cycle: the normalise compare/shift-up and the
// restoring reduce step (shift down, trial subtract, quotient bit).
module wdiv_step #(
    parameter int DW = 64
) (
    input  logic [2*DW-1:0] acc_i,
    input  logic [2*DW:0]   dsh_i,
    input  logic [2*DW-1:0] q_i,
    output logic            fits_o,
    output logic [2*DW:0]   dsh_up_o,
    output logic [2*DW:0]   dsh_dn_o,
    output logic [2*DW-1:0] acc_o,
    output logic [2*DW-1:0] q_o
);
    localparam int W2 = 2 * DW;

    logic [W2:0] acc_ext;
    logic [W2:0] diff;
    logic        borrow;

    always_comb begin
        acc_ext  = {1'b0, acc_i};
        fits_o   = (dsh_i <= acc_ext);
        dsh_up_o = {dsh_i[W2-1:0], 1'b0};
        dsh_dn_o = {1'b0, dsh_i[W2:1]};
        // both operands are below 2^W2, so the extra top bit is the borrow
        diff     = acc_ext - dsh_dn_o;
        borrow   = diff[W2];
        acc_o    = borrow ? acc_i : diff[W2-1:0];
        q_o      = {q_i[W2-2:0], ~borrow};
    end

endmodule

// File: rtl/wdiv_result_fix.sv
// Applies signs to the magnitude results and detects quotient overflow.
module wdiv_result_fix #(
    parameter int DW = 64
) (
    input  logic              signed_mode_i,
    input  logic [2*DW-1:0]   q_mag_i,
    input  logic [DW-1:0]     r_mag_i,
    input  logic              neg_q_i,
    input  logic              neg_r_i,
    output logic [DW-1:0]     quotient_o,
    output logic [DW-1:0]     remainder_o,
    output logic              overflow_o
);
    localparam int W2 = 2 * DW;
    localparam logic [W2-1:0] POS_LIMIT = {{(DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic [W2-1:0] NEG_LIMIT = POS_LIMIT + W2'(1);

    logic upper_set;

    always_comb begin
        upper_set = |q_mag_i[W2-1:DW];
        if (signed_mode_i) begin
            overflow_o = neg_q_i ? (q_mag_i > NEG_LIMIT) : (q_mag_i > POS_LIMIT);
        end else begin
            overflow_o = upper_set;
        end
        quotient_o  = neg_q_i ? (~q_mag_i[DW-1:0] + DW'(1)) : q_mag_i[DW-1:0];
        remainder_o = neg_r_i ? (~r_mag_i + DW'(1)) : r_mag_i;
    end

endmodule

// File: rtl/wide_divider.sv
module wide_divider
    import wdiv_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          signed_mode,
    input  logic [DW-1:0] dividend_hi,
    input  logic [DW-1:0] dividend_lo,
    input  logic [DW-1:0] divisor,
    output logic [DW-1:0] quotient,
    output logic [DW-1:0] remainder,
    output logic          div_err,
    output logic          done
);
    localparam int W2 = 2 * DW;
    localparam int NW = $clog2(W2 + 1);

    typedef struct packed {
        wdiv_state_e    st;
        logic [NW-1:0]  n;
        logic [W2:0]    dsh;
        logic [W2-1:0]  acc;
        logic [W2-1:0]  q;
        logic           sgn;
        logic           negq;
        logic           negr;
        logic [DW-1:0]  quo;
        logic [DW-1:0]  rem;
        logic           err;
        logic           done;
    } regs_t;

    regs_t r_q, r_d;

    logic [W2-1:0] mag_dd;
    logic [DW-1:0] mag_dv;
    logic          neg_dd, neg_dv;
    logic          fits;
    logic [W2:0]   dsh_up, dsh_dn;
    logic [W2-1:0] acc_nx, q_nx;
    logic [DW-1:0] fix_q, fix_r;
    logic          ovf;
    logic          running;

    wdiv_operand_prep #(.DW(DW)) u_prep (
        .signed_mode_i  (signed_mode),
        .dividend_i     ({dividend_hi, dividend_lo}),
        .divisor_i      (divisor),
        .mag_dividend_o (mag_dd),
        .mag_divisor_o  (mag_dv),
        .neg_dividend_o (neg_dd),
        .neg_divisor_o  (neg_dv)
    );

    wdiv_step #(.DW(DW)) u_step (
        .acc_i    (r_q.acc),
        .dsh_i    (r_q.dsh),
        .q_i      (r_q.q),
        .fits_o   (fits),
        .dsh_up_o (dsh_up),
        .dsh_dn_o (dsh_dn),
        .acc_o    (acc_nx),
        .q_o      (q_nx)
    );

    wdiv_result_fix #(.DW(DW)) u_fix (
        .signed_mode_i (r_q.sgn),
        .q_mag_i       (r_q.q),
        .r_mag_i       (r_q.acc[DW-1:0]),
        .neg_q_i       (r_q.negq),
        .neg_r_i       (r_q.negr),
        .quotient_o    (fix_q),
        .remainder_o   (fix_r),
        .overflow_o    (ovf)
    );

    assign running = (r_q.st != ST_IDLE);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_CHECK;
                    r_d.acc  = mag_dd;
                    r_d.dsh  = {{(W2+1-DW){1'b0}}, mag_dv};
                    r_d.q    = '0;
                    r_d.n    = '0;
                    r_d.sgn  = signed_mode;
                    r_d.negq = neg_dd ^ neg_dv;
                    r_d.negr = neg_dd;
                end
            end
            ST_CHECK: begin
                if (r_q.dsh == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                    r_d.quo  = '0;
                    r_d.rem  = '0;
                end else begin
                    r_d.st = ST_NORM;
                end
            end
            ST_NORM: begin
                if (fits && (r_q.n < NW'(W2))) begin
                    r_d.dsh = dsh_up;
                    r_d.n   = r_q.n + NW'(1);
                end else if (r_q.n == '0) begin
                    r_d.st = ST_FINISH;
                end else begin
                    r_d.st = ST_REDUCE;
                end
            end
            ST_REDUCE: begin
                r_d.dsh = dsh_dn;
                r_d.acc = acc_nx;
                r_d.q   = q_nx;
                r_d.n   = r_q.n - NW'(1);
                if (r_q.n == NW'(1)) begin
                    r_d.st = ST_FINISH;
                end
            end
            ST_FINISH: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
                r_d.err  = ovf;
                r_d.quo  = ovf ? '0 : fix_q;
                r_d.rem  = ovf ? '0 : fix_r;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign quotient  = r_q.quo;
    assign remainder = r_q.rem;
    assign div_err   = r_q.err;
    assign done      = r_q.done;

endmodule

// File: rtl/wdiv_checker.sv
module wdiv_checker #(
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          running,
    input logic          signed_mode,
    input logic [DW-1:0] divisor,
    input logic [DW-1:0] quotient,
    input logic [DW-1:0] remainder,
    input logic          div_err,
    input logic          done
);
    localparam int LIM = 4 * DW + 4;

    logic [DW-1:0] div_lat;
    logic          mode_lat;
    logic [15:0]   lat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_lat  <= '0;
            mode_lat <= 1'b0;
            lat_cnt  <= '0;
        end else if (start && !running) begin
            div_lat  <= divisor;
            mode_lat <= signed_mode;
            lat_cnt  <= 16'd1;
        end else if (running) begin
            lat_cnt  <= lat_cnt + 16'd1;
        end
    end

    assert_single_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(running));

    assert_hold_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((quotient != $past(quotient)) || (remainder != $past(remainder))) |-> done);

    assert_zero_divisor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !running && (divisor == '0)) |=> ##1 (done && div_err));

    assert_error_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_err) |-> ((quotient == '0) && (remainder == '0)));

    assert_unsigned_rem_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_err && !mode_lat) |-> (remainder < div_lat));

    assert_latency_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (lat_cnt <= 16'(LIM)));

endmodule

bind wide_divider wdiv_checker #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .running     (running),
    .signed_mode (signed_mode),
    .divisor     (divisor),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_err     (div_err),
    .done        (done)
);

// File: tb/tb_wide_divider.sv
`timescale 1ns/1ps
module tb_wide_divider;
    localparam int SW = 4;
    localparam int WW = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          s_start = 1'b0, s_sgn = 1'b0;
    logic [SW-1:0] s_hi = '0, s_lo = '0, s_dv = '0;
    logic [SW-1:0] s_q, s_r;
    logic          s_err, s_done;

    logic          w_start = 1'b0, w_sgn = 1'b0;
    logic [WW-1:0] w_hi = '0, w_lo = '0, w_dv = '0;
    logic [WW-1:0] w_q, w_r;
    logic          w_err, w_done;

    wide_divider #(.DW(SW)) dut (
        .clk(clk), .rst_n(rst_n), .start(s_start), .signed_mode(s_sgn),
        .dividend_hi(s_hi), .dividend_lo(s_lo), .divisor(s_dv),
        .quotient(s_q), .remainder(s_r), .div_err(s_err), .done(s_done)
    );

    wide_divider #(.DW(WW)) dut_wide (
        .clk(clk), .rst_n(rst_n), .start(w_start), .signed_mode(w_sgn),
        .dividend_hi(w_hi), .dividend_lo(w_lo), .divisor(w_dv),
        .quotient(w_q), .remainder(w_r), .div_err(w_err), .done(w_done)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        wait (cyc >= 190000);
        fails++;
        $display("FAIL R9 watchdog expired: cycles %0d expected below %0d", cyc, 190000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic small_op(input bit sg, input logic [7:0] n, input logic [3:0] d,
                            output int lat);
        @(negedge clk);
        s_sgn = sg; {s_hi, s_lo} = n; s_dv = d; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        lat = 1;
        while (!s_done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic wide_op(input bit sg, input logic [63:0] hi, input logic [63:0] lo,
                           input logic [63:0] d, output int lat);
        @(negedge clk);
        w_sgn = sg; w_hi = hi; w_lo = lo; w_dv = d; w_start = 1'b1;
        @(negedge clk);
        w_start = 1'b0;
        lat = 1;
        while (!w_done && lat < 400) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic wide_model(input bit sg, input logic [63:0] hi, input logic [63:0] lo,
                              input logic [63:0] d, output logic e,
                              output logic [63:0] q, output logic [63:0] r);
        logic [127:0] nn, mn, md, mq, mr;
        logic negn, negd, negq;
        nn   = {hi, lo};
        negn = sg && nn[127];
        negd = sg && d[63];
        mn   = negn ? (~nn + 128'd1) : nn;
        md   = {64'd0, negd ? (~d + 64'd1) : d};
        negq = negn ^ negd;
        if (d == 64'd0) begin
            e = 1'b1; q = '0; r = '0;
        end else begin
            mq = mn / md;
            mr = mn % md;
            if (!sg) e = (mq >= (128'd1 << 64));
            else if (negq) e = (mq > (128'd1 << 63));
            else e = (mq >= (128'd1 << 63));
            q = negq ? (~mq[63:0] + 64'd1) : mq[63:0];
            r = negn ? (~mr[63:0] + 64'd1) : mr[63:0];
            if (e) begin q = '0; r = '0; end
        end
    endtask

    task automatic wide_case(input bit sg, input logic [63:0] hi, input logic [63:0] lo,
                             input logic [63:0] d, input string tag);
        int lat;
        logic e;
        logic [63:0] q, r;
        wide_model(sg, hi, lo, d, e, q, r);
        wide_op(sg, hi, lo, d, lat);
        check({w_done, w_err, w_q, w_r} == {1'b1, e, q, r}, tag,
              {w_done, w_err, w_q, w_r}, {1'b1, e, q, r});
        check(lat <= 4 * WW + 4, "R9 wide latency", lat, 4 * WW + 4);
    endtask

    initial begin
        int lat;
        logic [SW-1:0] hq, hr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        check({s_done, s_err, s_q, s_r} == '0, "R7 reset small", {s_done, s_err, s_q, s_r}, 0);
        check({w_done, w_err, w_q, w_r} == '0, "R7 reset wide", {w_done, w_err, w_q, w_r}, 0);

        // Near-exhaustive sweep at DW=4: all signed dividends, even unsigned dividends
        for (int sg = 0; sg < 2; sg++) begin
            for (int nn = 0; nn < 256; nn += (sg == 1) ? 1 : 2) begin
                for (int dd = 0; dd < 16; dd++) begin
                    int nv, dv, qi, ri;
                    bit e;
                    logic [SW-1:0] eq, er;
                    string tag;
                    nv = (sg == 1) ? int'($signed(8'(nn))) : nn;
                    dv = (sg == 1) ? int'($signed(4'(dd))) : dd;
                    qi = 0; ri = 0;
                    if (dv == 0) e = 1'b1;
                    else begin
                        qi = nv / dv;
                        ri = nv % dv;
                        e = (sg == 1) ? (qi < -8 || qi > 7) : (qi > 15);
                    end
                    eq = e ? '0 : SW'(qi);
                    er = e ? '0 : SW'(ri);
                    if (dv == 0) tag = "R3 R6 zero divisor";
                    else if (e) tag = (sg == 1) ? "R5 R6 signed overflow" : "R4 R6 unsigned overflow";
                    else tag = (sg == 1) ? "R2 signed result" : "R1 unsigned result";
                    small_op(sg[0], 8'(nn), 4'(dd), lat);
                    check({s_done, s_err, s_q, s_r} == {1'b1, e, eq, er}, tag,
                          {s_done, s_err, s_q, s_r}, {1'b1, e, eq, er});
                    if (dv == 0)
                        check(lat == 2, "R3 zero divisor turnaround", lat, 2);
                    else if (sg == 0 && nn < dd)
                        check(lat == 4, "R9 small dividend latency", lat, 4);
                    else
                        check(lat <= 4 * SW + 4, "R9 latency bound", lat, 4 * SW + 4);
                end
            end
        end

        // R8: start during a running operation is ignored
        @(negedge clk);
        s_sgn = 1'b0; {s_hi, s_lo} = 8'h3C; s_dv = 4'd4; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        @(negedge clk);
        s_dv = 4'd0; {s_hi, s_lo} = 8'h11; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        lat = 0;
        while (!s_done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check({s_done, s_err, s_q, s_r} == {1'b1, 1'b0, 4'd15, 4'd0}, "R8 ignored start result",
              {s_done, s_err, s_q, s_r}, {1'b1, 1'b0, 4'd15, 4'd0});
        hq = s_q; hr = s_r;
        begin
            bit extra;
            extra = 1'b0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (s_done) extra = 1'b1;
            end
            check(!extra, "R8 no second completion", extra, 0);
        end
        // R7: outputs held after completion
        check({s_q, s_r} == {hq, hr}, "R7 outputs held", {s_q, s_r}, {hq, hr});

        // 64-bit cases
        wide_case(1'b0, 64'd0, 64'd1_000_000_000_000_007, 64'd12345, "R1 wide unsigned");
        wide_case(1'b0, 64'h0000_0000_0000_04D2, 64'h9E37_79B9_7F4A_7C15,
                  64'hFFFF_FFFF_FFFF_FFFF, "R1 wide full-width");
        wide_case(1'b0, 64'd7, 64'd9, 64'd0, "R3 R6 wide zero divisor");
        wide_case(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd9, 64'd0, "R3 R6 wide signed zero divisor");
        wide_case(1'b0, 64'd5, 64'd0, 64'd5, "R4 R6 wide unsigned overflow");
        wide_case(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'd1,
                  "R5 wide most negative quotient fits");
        wide_case(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
                  64'hFFFF_FFFF_FFFF_FFFF, "R5 R6 wide negate overflow");
        wide_case(1'b1, 64'h8000_0000_0000_0000, 64'd0, 64'd2, "R5 R6 wide most negative dividend");
        wide_case(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FF9C, 64'd7,
                  "R2 wide negative dividend");
        wide_case(1'b1, 64'd0, 64'h4000_0000_0000_0000, 64'h8000_0000_0000_0000,
                  "R2 wide most negative divisor");
        wide_case(1'b1, 64'd0, 64'd1000, 64'hFFFF_FFFF_FFFF_FFFD, "R2 wide negative divisor");
        wide_op(1'b0, 64'd0, 64'd5, 64'd9, lat);
        check({w_err, w_q, w_r} == {1'b0, 64'd0, 64'd5}, "R9 wide small dividend result",
              {w_err, w_q, w_r}, {1'b0, 64'd0, 64'd5});
        check(lat == 4, "R9 wide small dividend latency", lat, 4);
        wide_case(1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
                  "R1 wide top quotient");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule